// File: doc/BRIEF.md
# Per-Line Longitudinal Check and Character Parity Unit

This block adds two checks to the character path of a multi-line serial controller. The first is a longitudinal redundancy check that is kept separately for every line. Each character the host places into a line's buffer updates that line's 8-bit check register by XOR, and so does each character the host takes out of the buffer. A move command returns the accumulated check character, so the host can place it in the buffer, and sets the register back to zero. Because both directions accumulate, a message can be checked on receive. The host reads every data character and then the received check character, issues a move, and a zero result shows that the two checks agree.

The second check is character parity. On the transmit side, the top bit of the character acts as an indicator and is replaced by a generated parity bit when the character is loaded for shifting out. A 0 indicator produces odd parity and a 1 produces even parity, counted over the whole character. On the receive side, the character is handed on unchanged, together with a flag that reports whether its overall parity is even. Each feature has its own enable. When a feature is disabled, characters pass through it unchanged.

Top module: `lrc_parity_unit`

## Requirements
- R1: After synchronous reset, every line's check register reads zero and `mv_valid`, `tx_valid` and `rx_valid` are low.
- R2: A command with `cmd_op` = 0 (character written into the buffer) while `lrc_en` is high XORs `cmd_char` into the check register of line `cmd_line`.
- R3: A command with `cmd_op` = 1 (character read out of the buffer) while `lrc_en` is high XORs `cmd_char` into the check register of line `cmd_line`.
- R4: A command with `cmd_op` = 2 (move) raises `mv_valid` for one cycle on the next clock, with `mv_char` equal to the line's register value before the command. The register is then zero, so an immediate second move on the same line returns 0.
- R5: Commands change only the register of the addressed line.
- R6: A command with `cmd_op` = 3 (transmit) leaves the check register unchanged and does not raise `mv_valid`.
- R7: While `lrc_en` is low, write and read commands leave the check register unchanged. The move command still copies the register and clears it.
- R8: A `tx_load` produces `tx_valid` on the next clock. When `par_en` is high, bits CHAR_W-2..0 of `tx_char` equal those of `tx_in`. If indicator bit CHAR_W-1 of `tx_in` is 0, bit CHAR_W-1 of `tx_char` is set so that the total number of ones in `tx_char` is odd.
- R9: If the indicator bit is 1 while `par_en` is high, bit CHAR_W-1 of `tx_char` is set so that the total number of ones in `tx_char` is even.
- R10: While `par_en` is low, `tx_char` equals `tx_in` unchanged.
- R11: An `rx_load` produces `rx_valid` on the next clock, with `rx_char` equal to `rx_in` including its top bit. `rx_even` is 1 when `par_en` is high and `rx_in` has an even number of ones; otherwise it is 0.
- R12: If a line's register is zero and the host reads a message followed by a character equal to the XOR of that message, a following move on that line returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lrc_en | input | 1 | Enables check accumulation |
| par_en | input | 1 | Enables parity insertion and reporting |
| cmd_valid | input | 1 | Line command strobe |
| cmd_op | input | 2 | 0 write, 1 read, 2 move, 3 transmit |
| cmd_line | input | LINE_W | Addressed line |
| cmd_char | input | CHAR_W | Character moved by a write or read |
| mv_valid | output | 1 | Move result valid |
| mv_char | output | CHAR_W | Check character returned by a move |
| tx_load | input | 1 | Load a character for shifting out |
| tx_in | input | CHAR_W | Character carrying the parity indicator |
| tx_valid | output | 1 | Transmit character valid |
| tx_char | output | CHAR_W | Character with parity inserted |
| rx_load | input | 1 | Assembled received character strobe |
| rx_in | input | CHAR_W | Received character |
| rx_valid | output | 1 | Received character valid |
| rx_char | output | CHAR_W | Received character passed on |
| rx_even | output | 1 | Received character has even parity |

## Verification
A corrupted check register stays hidden until the next move on that line. The move then returns a wrong `mv_char` one clock after the command, so every accumulation scenario ends with a move, and then with a second move that must return zero. A wrong parity decision shows up on `tx_char` or `rx_even` in the cycle after the load, so each load is checked at that point against a ones count made in the bench. The per-line independence check also exposes a decoding error that hits the wrong line.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    localparam int unsigned MAX_CHAR_W = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_MOVE  = 2'd2,
        OP_XMIT  = 2'd3
    } line_op_e;

    typedef struct packed {
        logic     acc;
        logic     clr;
        line_op_e op;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic valid, input logic [1:0] op_bits,
                                            input logic acc_enable);
        cmd_dec_t d;
        d.op  = line_op_e'(op_bits);
        d.acc = valid && acc_enable && (d.op == OP_WRITE || d.op == OP_READ);
        d.clr = valid && (d.op == OP_MOVE);
        return d;
    endfunction

endpackage

// File: rtl/lrc_bank.sv
module lrc_bank #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned CHAR_W    = 8,
    localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              clr,
    input  logic [LINE_W-1:0] sel_line,
    input  logic [CHAR_W-1:0] acc_char,
    output logic [CHAR_W-1:0] cur_lrc
);

    logic [CHAR_W-1:0] lrc_arr [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic              hit;
        logic [CHAR_W-1:0] acc_q;

        assign hit = (sel_line == LINE_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (clr && hit) begin
                acc_q <= '0;
            end else if (acc && hit) begin
                acc_q <= acc_q ^ acc_char;
            end
        end

        assign lrc_arr[g] = acc_q;
    end

    assign cur_lrc = lrc_arr[sel_line];

endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              par_en,
    input  logic [CHAR_W-1:0] char_in,
    output logic              valid_q,
    output logic [CHAR_W-1:0] char_q
);

    localparam int unsigned LOW_W = CHAR_W - 1;

    logic [LOW_W-1:0]  low_bits;
    logic              indicator;
    logic              par_bit;
    logic [CHAR_W-1:0] shaped;

    always_comb begin
        low_bits  = char_in[LOW_W-1:0];
        indicator = char_in[CHAR_W-1];
        par_bit   = (^low_bits) ^ ~indicator;
        shaped    = par_en ? {par_bit, low_bits} : char_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            char_q  <= '0;
        end else begin
            valid_q <= load;
            if (load) begin
                char_q <= shaped;
            end
        end
    end

endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              par_en,
    input  logic [CHAR_W-1:0] char_in,
    output logic              valid_q,
    output logic [CHAR_W-1:0] char_q,
    output logic              even_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            char_q  <= '0;
            even_q  <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                char_q <= char_in;
                even_q <= par_en & ~(^char_in);
            end
        end
    end

endmodule

// File: rtl/lrc_parity_unit.sv
module lrc_parity_unit #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned CHAR_W    = 8,
    localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lrc_en,
    input  logic              par_en,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [CHAR_W-1:0] cmd_char,
    output logic              mv_valid,
    output logic [CHAR_W-1:0] mv_char,
    input  logic              tx_load,
    input  logic [CHAR_W-1:0] tx_in,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_char,
    input  logic              rx_load,
    input  logic [CHAR_W-1:0] rx_in,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_char,
    output logic              rx_even
);
    import lrc_pkg::*;

    initial begin
        if (CHAR_W < 2 || CHAR_W > MAX_CHAR_W) $error("CHAR_W out of range");
    end

    cmd_dec_t          dec;
    logic [CHAR_W-1:0] cur_lrc;

    assign dec = decode_cmd(cmd_valid, cmd_op, lrc_en);

    lrc_bank #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .acc      (dec.acc),
        .clr      (dec.clr),
        .sel_line (cmd_line),
        .acc_char (cmd_char),
        .cur_lrc  (cur_lrc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mv_valid <= 1'b0;
            mv_char  <= '0;
        end else begin
            mv_valid <= dec.clr;
            if (dec.clr) begin
                mv_char <= cur_lrc;
            end
        end
    end

    tx_parity_gen #(.CHAR_W(CHAR_W)) i_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .par_en  (par_en),
        .char_in (tx_in),
        .valid_q (tx_valid),
        .char_q  (tx_char)
    );

    rx_parity_chk #(.CHAR_W(CHAR_W)) i_rx (
        .clk     (clk),
        .rst     (rst),
        .load    (rx_load),
        .par_en  (par_en),
        .char_in (rx_in),
        .valid_q (rx_valid),
        .char_q  (rx_char),
        .even_q  (rx_even)
    );

endmodule

// File: rtl/lrc_parity_checker.sv
module lrc_parity_checker #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned LINE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              par_en,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [LINE_W-1:0] cmd_line,
    input logic              mv_valid,
    input logic [CHAR_W-1:0] mv_char,
    input logic              tx_load,
    input logic [CHAR_W-1:0] tx_in,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_char,
    input logic              rx_load,
    input logic [CHAR_W-1:0] rx_in,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic              rx_even
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mv_valid && !tx_valid && !rx_valid));

    p_move_latency_r4: assert property (@(posedge clk) disable iff (rst)
        mv_valid == $past(cmd_valid && cmd_op == 2'd2));

    p_move_twice_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && $past(mv_valid) && $past(cmd_line) == $past(cmd_line, 2)) |-> (mv_char == '0));

    p_xmit_no_move_r6: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == 2'd3) |-> !mv_valid);

    p_tx_latency_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid == $past(tx_load));

    p_tx_low_bits_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_char[CHAR_W-2:0] == $past(tx_in[CHAR_W-2:0])));

    p_tx_parity_sense_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && $past(par_en)) |-> ((^tx_char) == ~$past(tx_in[CHAR_W-1])));

    p_tx_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !$past(par_en)) |-> (tx_char == $past(tx_in)));

    p_rx_data_r11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_char == $past(rx_in) && rx_valid == $past(rx_load)));

    p_rx_flag_off_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !$past(par_en)) |-> !rx_even);

endmodule

bind lrc_parity_unit lrc_parity_checker #(.CHAR_W(CHAR_W), .LINE_W(LINE_W)) i_lrc_parity_checker (
    .clk       (clk),
    .rst       (rst),
    .par_en    (par_en),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_line  (cmd_line),
    .mv_valid  (mv_valid),
    .mv_char   (mv_char),
    .tx_load   (tx_load),
    .tx_in     (tx_in),
    .tx_valid  (tx_valid),
    .tx_char   (tx_char),
    .rx_load   (rx_load),
    .rx_in     (rx_in),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char),
    .rx_even   (rx_even)
);

// File: tb/test_lrc_parity_unit.sv
`timescale 1ns/1ps
module test_lrc_parity_unit;

    localparam int unsigned NUM_LINES = 64;
    localparam int unsigned CHAR_W    = 8;
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lrc_en = 1'b1;
    logic              par_en = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [LINE_W-1:0] cmd_line = '0;
    logic [CHAR_W-1:0] cmd_char = '0;
    logic              mv_valid;
    logic [CHAR_W-1:0] mv_char;
    logic              tx_load = 1'b0;
    logic [CHAR_W-1:0] tx_in = '0;
    logic              tx_valid;
    logic [CHAR_W-1:0] tx_char;
    logic              rx_load = 1'b0;
    logic [CHAR_W-1:0] rx_in = '0;
    logic              rx_valid;
    logic [CHAR_W-1:0] rx_char;
    logic              rx_even;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lrc_parity_unit #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W)) i_lrc_parity_unit (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int line, input logic [CHAR_W-1:0] ch);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_line  = LINE_W'(line);
        cmd_char  = ch;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic move_expect(input int line, input logic [CHAR_W-1:0] exp, input string tag);
        issue(2'd2, line, '0);
        check(mv_valid == 1'b1, tag, int'(mv_valid), 1);
        check(mv_char == exp, tag, int'(mv_char), int'(exp));
    endtask

    function automatic logic [CHAR_W-1:0] tx_model(input logic [CHAR_W-1:0] c, input bit pen);
        int  ones;
        bit  pbit;
        if (!pen) return c;
        ones = $countones(c[CHAR_W-2:0]);
        pbit = c[CHAR_W-1] ? (ones % 2 == 1) : (ones % 2 == 0);
        return {pbit, c[CHAR_W-2:0]};
    endfunction

    task automatic tx_expect(input logic [CHAR_W-1:0] c, input string tag);
        logic [CHAR_W-1:0] exp;
        exp = tx_model(c, par_en);
        @(negedge clk);
        tx_load = 1'b1;
        tx_in   = c;
        @(negedge clk);
        tx_load = 1'b0;
        check(tx_valid == 1'b1, tag, int'(tx_valid), 1);
        check(tx_char == exp, tag, int'(tx_char), int'(exp));
    endtask

    task automatic rx_expect(input logic [CHAR_W-1:0] c, input string tag);
        bit exp_even;
        exp_even = par_en && ($countones(c) % 2 == 0);
        @(negedge clk);
        rx_load = 1'b1;
        rx_in   = c;
        @(negedge clk);
        rx_load = 1'b0;
        check(rx_valid == 1'b1 && rx_char == c, tag, int'(rx_char), int'(c));
        check(rx_even == exp_even, tag, int'(rx_even), int'(exp_even));
    endtask

    task automatic t_reset_r1;
        check(!mv_valid && !tx_valid && !rx_valid, "R1 valids low",
              int'({mv_valid, tx_valid, rx_valid}), 0);
        move_expect(5, 8'h00, "R1 line 5 zero");
        move_expect(NUM_LINES - 1, 8'h00, "R1 last line zero");
    endtask

    task automatic t_accumulate_r2_r3;
        issue(2'd0, 3, 8'h41);
        issue(2'd0, 3, 8'hC2);
        issue(2'd1, 3, 8'h13);
        move_expect(3, 8'h41 ^ 8'hC2 ^ 8'h13, "R2 R3 mixed xor");
        move_expect(3, 8'h00, "R4 cleared after move");
        issue(2'd1, 3, 8'hA5);
        move_expect(3, 8'hA5, "R3 read only");
    endtask

    task automatic t_lines_r5;
        issue(2'd0, 1, 8'h0F);
        issue(2'd0, 2, 8'hF0);
        issue(2'd0, 1, 8'h01);
        move_expect(2, 8'hF0, "R5 line 2 own value");
        move_expect(1, 8'h0E, "R5 line 1 own value");
        move_expect(0, 8'h00, "R5 line 0 untouched");
    endtask

    task automatic t_xmit_r6;
        issue(2'd0, 4, 8'h3C);
        issue(2'd3, 4, 8'hFF);
        check(mv_valid == 1'b0, "R6 no move result", int'(mv_valid), 0);
        move_expect(4, 8'h3C, "R6 register kept");
    endtask

    task automatic t_lrc_off_r7;
        issue(2'd0, 6, 8'h55);
        lrc_en = 1'b0;
        issue(2'd0, 6, 8'h0F);
        issue(2'd1, 6, 8'hF0);
        move_expect(6, 8'h55, "R7 disabled no accumulate");
        move_expect(6, 8'h00, "R7 move still clears");
        lrc_en = 1'b1;
    endtask

    task automatic t_tx_parity_r8_r9;
        tx_expect(8'h00, "R8 odd zero data");
        tx_expect(8'h41, "R8 odd two ones");
        tx_expect(8'h07, "R8 odd three ones");
        tx_expect(8'h80, "R9 even zero data");
        tx_expect(8'hC1, "R9 even two ones");
        tx_expect(8'hFF, "R9 even seven ones");
    endtask

    task automatic t_tx_pass_r10;
        par_en = 1'b0;
        tx_expect(8'h41, "R10 passthrough a");
        tx_expect(8'h80, "R10 passthrough b");
        par_en = 1'b1;
    endtask

    task automatic t_rx_r11;
        rx_expect(8'h03, "R11 even");
        rx_expect(8'h83, "R11 odd");
        rx_expect(8'h00, "R11 zero even");
        par_en = 1'b0;
        rx_expect(8'h03, "R11 disabled flag low");
        par_en = 1'b1;
    endtask

    task automatic t_rx_check_r12;
        logic [CHAR_W-1:0] sum;
        logic [CHAR_W-1:0] msg [4];
        msg[0] = 8'h48; msg[1] = 8'hE9; msg[2] = 8'h21; msg[3] = 8'h7E;
        sum = '0;
        for (int i = 0; i < 4; i++) begin
            issue(2'd1, 7, msg[i]);
            sum ^= msg[i];
        end
        issue(2'd1, 7, sum);
        move_expect(7, 8'h00, "R12 matching check is zero");
        for (int i = 0; i < 4; i++) issue(2'd1, 9, msg[i]);
        issue(2'd1, 9, sum ^ 8'h10);
        move_expect(9, 8'h10, "R12 mismatch nonzero");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_accumulate_r2_r3();
        t_lines_r5();
        t_xmit_r6();
        t_lrc_off_r7();
        t_tx_parity_r8_r9();
        t_tx_pass_r10();
        t_rx_r11();
        t_rx_check_r12();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule